// File: doc/BRIEF.md
# Programmable Video Timing Generator

This block produces the raster timing a display transmitter needs: horizontal sync, vertical sync, a data-enable strobe and the current pixel column and line. It advances one pixel per clock. Software programs the geometry through a small register write port. Four packed timing words give the active size, the front porch, the sync pulse width and a combined span that runs from sync start to the end of the line or frame. A fifth word sets the sync polarities.

Each interval is written as its length minus one. Every horizontal field sits in the low half of a word and every vertical field in the high half. Timing and polarity writes go to a shadow set. The shadow set is copied into the working set only on the last pixel of a frame, so a running frame never mixes old and new values. A control word starts and stops generation. It also holds a mode flag that is passed through unchanged as a status output for the downstream encoder.

Top module: `disp_timing_gen`

## Requirements
- R1: Register address 0 is the control word. Bit 31 enables generation and bit 30 is the mode flag. Both take effect on the clock edge that performs the write. `hdmi_mode` follows bit 30 whether or not generation is enabled.
- R2: After reset, or while generation is disabled, `pos_x` and `pos_y` are 0 and `de` is 0. `hsync` and `vsync` sit at their inactive level. After reset both polarity bits are 0, so both syncs are high.
- R3: Addresses 1 to 4 hold the active size, the back span, the front porch and the sync width, in that order. Each word carries the horizontal length minus one in bits 11:0 and the vertical length minus one in bits 27:16.
- R4: A line of H columns has three parts in order: the active width A, then the front porch F, then the back span B. The sync pulse of width S starts the back span, so H = A+F+B. `hsync` is asserted for the columns from A+F up to A+F+S-1.
- R5: A frame is built from lines in the same order, using the vertical fields. `vsync` is asserted for whole lines, from line Av+Fv up to line Av+Fv+Sv-1.
- R6: `de` is 1 exactly when the column is below A and the line is below Av.
- R7: Address 5 is the polarity word. When bit 0 is 1, `hsync` is active-high; when it is 0, `hsync` is active-low. Bit 1 sets `vsync` the same way.
- R8: `pos_x` and `pos_y` report the current column and line. They read (0,0) in the first cycle after the enable edge and advance one pixel per clock.
- R9: A write to addresses 1 to 5 while generation is enabled first affects the frame that starts after the current frame's last pixel. While generation is disabled, a write takes effect one cycle after the write edge.
- R10: Clearing the enable bit in the middle of a frame forces the idle outputs in the next cycle. Enabling again restarts at pixel (0,0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 32 | Register write data |
| hsync | output | 1 | Horizontal sync, polarity programmable |
| vsync | output | 1 | Vertical sync, polarity programmable |
| de | output | 1 | Data enable, high in the visible area |
| pos_x | output | CW (14) | Current column |
| pos_y | output | CW (14) | Current line |
| hdmi_mode | output | 1 | Mode flag from control bit 30 |

## Verification
A miscounted horizontal counter shows up within one line as a `pos_x` step other than one, or as `hsync` or `de` edges in the wrong column. A vertical fault shows up at the first line wrap. A working set that loads at the wrong moment is seen only at the next frame boundary: the first frame after a mid-frame rewrite then takes the wrong geometry or polarity. The bench sweeps every pixel of several small frames and compares each output against arithmetic expectations. It covers a rewrite that lands mid-frame, the minimum geometry of one pixel per interval, and a stop and restart.

// File: rtl/vtg_pkg.sv
// Package: shared register addresses and bit positions for the video timing generator.
// Assumes a 3-bit register address and a 32-bit write word.
package vtg_pkg;
    localparam logic [2:0] VTG_ADDR_CTRL  = 3'd0;
    localparam logic [2:0] VTG_ADDR_TIME0 = 3'd1;  // first of four timing words
    localparam logic [2:0] VTG_ADDR_POL   = 3'd5;
    localparam int VTG_EN_BIT   = 31;
    localparam int VTG_MODE_BIT = 30;
    localparam int VTG_V_LSB    = 16;              // vertical field start in a timing word
    localparam int VTG_NFIELDS  = 4;               // active, back span, front, sync
    localparam int VTG_F_ACT    = 0;
    localparam int VTG_F_BACK   = 1;
    localparam int VTG_F_FRONT  = 2;
    localparam int VTG_F_SYNC   = 3;
endpackage

// File: rtl/vtg_regs.sv
// Module: vtg_regs
// Holds the control word, the shadow timing/polarity set written by software,
// and the working set used by the counters. The working set copies the shadow
// whenever 'load' is high (frame end, or generation stopped).
// Assumes FW <= 16 so both fields fit their halves of a 32-bit word.
module vtg_regs
    import vtg_pkg::*;
#(
    parameter int FW = 12
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [2:0]                        wr_addr,
    input  logic [31:0]                       wr_data,
    input  logic                              load,
    output logic                              en,
    output logic                              mode,
    output logic [VTG_NFIELDS-1:0][FW-1:0]    wk_h,
    output logic [VTG_NFIELDS-1:0][FW-1:0]    wk_v,
    output logic                              pol_h,
    output logic                              pol_v
);
    logic [VTG_NFIELDS-1:0][FW-1:0] sh_h;
    logic [VTG_NFIELDS-1:0][FW-1:0] sh_v;
    logic [1:0]                     sh_pol;
    logic                           unused_bits;

    assign unused_bits = ^wr_data;

    // Control word: enable and mode flag, applied immediately.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en   <= 1'b0;
            mode <= 1'b0;
        end else if (wr_en && wr_addr == VTG_ADDR_CTRL) begin
            en   <= wr_data[VTG_EN_BIT];
            mode <= wr_data[VTG_MODE_BIT];
        end
    end

    // One shadow register pair per timing word.
    for (genvar k = 0; k < VTG_NFIELDS; k++) begin : g_shadow
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sh_h[k] <= '0;
                sh_v[k] <= '0;
            end else if (wr_en && wr_addr == VTG_ADDR_TIME0 + 3'(k)) begin
                sh_h[k] <= wr_data[FW-1:0];
                sh_v[k] <= wr_data[VTG_V_LSB +: FW];
            end
        end
    end

    // Shadow polarity word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_pol <= 2'b00;
        end else if (wr_en && wr_addr == VTG_ADDR_POL) begin
            sh_pol <= wr_data[1:0];
        end
    end

    // Working set: copied from the shadow at frame boundaries or while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wk_h  <= '0;
            wk_v  <= '0;
            pol_h <= 1'b0;
            pol_v <= 1'b0;
        end else if (load) begin
            wk_h  <= sh_h;
            wk_v  <= sh_v;
            pol_h <= sh_pol[0];
            pol_v <= sh_pol[1];
        end
    end
endmodule

// File: rtl/vtg_axis.sv
// Module: vtg_axis
// One raster axis: a counter that advances on 'step' while 'run' is high and
// wraps after the last position. Decodes the active and sync regions from
// fields stored as length minus one.
// Assumes the sync width does not exceed the back span.
module vtg_axis
    import vtg_pkg::*;
#(
    parameter int FW = 12,
    parameter int CW = FW + 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            run,
    input  logic                            step,
    input  logic [VTG_NFIELDS-1:0][FW-1:0]  cfg,
    output logic [CW-1:0]                   count,
    output logic                            active,
    output logic                            in_sync,
    output logic                            at_end
);
    logic [CW-1:0] len_act, len_front, len_sync, len_back;
    logic [CW-1:0] sync_lo, sync_hi, last_pos;

    // Lengths from minus-one fields and region boundaries.
    always_comb begin
        len_act   = CW'(cfg[VTG_F_ACT])   + 1'b1;
        len_front = CW'(cfg[VTG_F_FRONT]) + 1'b1;
        len_sync  = CW'(cfg[VTG_F_SYNC])  + 1'b1;
        len_back  = CW'(cfg[VTG_F_BACK])  + 1'b1;
        sync_lo   = len_act + len_front;
        sync_hi   = sync_lo + len_sync;
        last_pos  = sync_lo + len_back - 1'b1;
    end

    assign active  = count < len_act;
    assign in_sync = (count >= sync_lo) && (count < sync_hi);
    assign at_end  = count == last_pos;

    // Position counter: cleared while stopped, wraps at the last position.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            count <= '0;
        end else if (step) begin
            count <= at_end ? '0 : count + 1'b1;
        end
    end
endmodule

// File: rtl/disp_timing_gen.sv
// Module: disp_timing_gen (top)
// Programmable raster timing generator: register port, working/shadow sets,
// horizontal and vertical counters, and gated sync/enable/position outputs.
// Assumes one pixel per clock and software that keeps sync width <= back span.
module disp_timing_gen
    import vtg_pkg::*;
#(
    parameter int FW = 12,
    parameter int CW = FW + 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [2:0]      wr_addr,
    input  logic [31:0]     wr_data,
    output logic            hsync,
    output logic            vsync,
    output logic            de,
    output logic [CW-1:0]   pos_x,
    output logic [CW-1:0]   pos_y,
    output logic            hdmi_mode
);
    logic                           run;
    logic                           load;
    logic [VTG_NFIELDS-1:0][FW-1:0] wk_h, wk_v;
    logic                           pol_h, pol_v;
    logic [CW-1:0]                  hcnt, vcnt;
    logic                           h_act, h_sync, h_end;
    logic                           v_act, v_sync, v_end;

    vtg_regs #(.FW(FW)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .load(load), .en(run), .mode(hdmi_mode),
        .wk_h(wk_h), .wk_v(wk_v), .pol_h(pol_h), .pol_v(pol_v)
    );

    vtg_axis #(.FW(FW), .CW(CW)) h_axis_i (
        .clk(clk), .rst_n(rst_n), .run(run), .step(1'b1), .cfg(wk_h),
        .count(hcnt), .active(h_act), .in_sync(h_sync), .at_end(h_end)
    );

    vtg_axis #(.FW(FW), .CW(CW)) v_axis_i (
        .clk(clk), .rst_n(rst_n), .run(run), .step(h_end), .cfg(wk_v),
        .count(vcnt), .active(v_act), .in_sync(v_sync), .at_end(v_end)
    );

    // Working set reloads on the last pixel of a frame or while stopped.
    assign load = !run || (h_end && v_end);

    // Outputs gated by enable so the idle state appears at once.
    always_comb begin
        de    = run && h_act && v_act;
        hsync = (run && h_sync) ? pol_h : ~pol_h;
        vsync = (run && v_sync) ? pol_v : ~pol_v;
        pos_x = run ? hcnt : '0;
        pos_y = run ? vcnt : '0;
    end
endmodule

// File: rtl/vtg_checker.sv
// Module: vtg_checker
// Temporal checks on the timing generator outputs, bound into the top.
// Assumes every interval is at least one pixel, so a line is at least 3 wide.
module vtg_checker #(
    parameter int CW = 14
) (
    input logic          clk,
    input logic          rst_n,
    input logic          en,
    input logic          de,
    input logic [CW-1:0] pos_x,
    input logic [CW-1:0] pos_y
);
    // R2: idle outputs while stopped.
    a_r2_idle_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> (pos_x == '0 && pos_y == '0 && !de));

    // R8: generation starts at the origin.
    a_r8_start_origin: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(en) |-> (pos_x == '0 && pos_y == '0));

    // R4: columns advance by one inside a line.
    a_r4_x_step: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && pos_x != '0) |-> pos_x == $past(pos_x) + 1'b1);

    // R4: a wrap to column 0 never repeats in consecutive cycles.
    a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && pos_x == '0) |-> $past(pos_x) != '0);

    // R5: the line only changes when the column wraps.
    a_r5_y_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (en && $past(en) && pos_x != '0) |-> pos_y == $past(pos_y));

    // R6: the origin is always visible.
    a_r6_de_origin: assert property (@(posedge clk) disable iff (!rst_n)
        (en && pos_x == '0 && pos_y == '0) |-> de);
endmodule

bind disp_timing_gen vtg_checker #(.CW(CW)) chk_i (
    .clk(clk), .rst_n(rst_n), .en(run), .de(de), .pos_x(pos_x), .pos_y(pos_y)
);

// File: tb/disp_timing_gen_tb_top.sv
`timescale 1ns/1ps
// Bench: full-frame pixel sweeps of small geometries against arithmetic expectations.
module disp_timing_gen_tb_top;
    localparam int CW = 14;

    typedef struct {
        int ha, hf, hs, hb;
        int va, vf, vs, vb;
        int pol;
    } cfg_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [2:0]    wr_addr = '0;
    logic [31:0]   wr_data = '0;
    logic          hsync, vsync, de, hdmi_mode;
    logic [CW-1:0] pos_x, pos_y;

    int ncheck = 0;
    int nfail  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    disp_timing_gen dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .hsync(hsync), .vsync(vsync), .de(de),
        .pos_x(pos_x), .pos_y(pos_y), .hdmi_mode(hdmi_mode)
    );

    task automatic chk(string tag, int got, int exp);
        ncheck++;
        if (got != exp) begin
            nfail++;
            $display("FAIL %s got %0d expected %0d", tag, got, exp);
        end
    endtask

    // R3: horizontal length-1 in bits 11:0, vertical length-1 in bits 27:16.
    function automatic logic [31:0] pack(int h, int v);
        return 32'(((v - 1) << 16) | (h - 1));
    endfunction

    function automatic int frame_len(cfg_t c);
        return (c.ha + c.hf + c.hb) * (c.va + c.vf + c.vb);
    endfunction

    function automatic logic [31:0] cfg_word(cfg_t c, int idx);
        case (idx)
            0: return pack(c.ha, c.va);
            1: return pack(c.hb, c.vb);
            2: return pack(c.hf, c.vf);
            3: return pack(c.hs, c.vs);
            default: return 32'(c.pol);
        endcase
    endfunction

    task automatic write_reg(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic load_cfg(cfg_t c);
        for (int i = 0; i < 5; i++) write_reg(3'(i + 1), cfg_word(c, i));
    endtask

    // Expected outputs for pixel n of a free-running raster with config c.
    task automatic expect_pix(cfg_t c, int n, string sfx);
        int th, tv, m, x, y;
        bit xs, ys, pd;
        th = c.ha + c.hf + c.hb;
        tv = c.va + c.vf + c.vb;
        m  = n % (th * tv);
        x  = m % th;
        y  = m / th;
        xs = (x >= c.ha + c.hf) && (x < c.ha + c.hf + c.hs);
        ys = (y >= c.va + c.vf) && (y < c.va + c.vf + c.vs);
        pd = (x < c.ha) && (y < c.va);
        chk({"R8 pos_x ", sfx}, int'(pos_x), x);
        chk({"R8 pos_y ", sfx}, int'(pos_y), y);
        chk({"R6 de ", sfx}, int'(de), int'(pd));
        chk({"R4/R7 hsync ", sfx}, int'(hsync), xs ? (c.pol & 1) : 1 - (c.pol & 1));
        chk({"R5/R7 vsync ", sfx}, int'(vsync), ys ? ((c.pol >> 1) & 1) : 1 - ((c.pol >> 1) & 1));
    endtask

    // Sweep ncyc pixels starting at pixel 0; optionally rewrite to c1 from pixel inj.
    task automatic sweep(cfg_t c0, cfg_t c1, int inj, int ncyc, string sfx);
        int sw;
        sw = (inj >= 0) ? (inj / frame_len(c0) + 1) * frame_len(c0) : 32'h7fff_ffff;
        for (int n = 0; n < ncyc; n++) begin
            if (n < sw) expect_pix(c0, n, sfx);
            else        expect_pix(c1, n - sw, {"R9 ", sfx});
            if (inj >= 0 && n >= inj && n < inj + 5) begin
                wr_en = 1'b1; wr_addr = 3'(n - inj + 1); wr_data = cfg_word(c1, n - inj);
            end else begin
                wr_en = 1'b0;
            end
            @(negedge clk);
        end
        wr_en = 1'b0;
    endtask

    initial begin
        cfg_t c1, c2, cmin;
        c1   = '{ha:8, hf:2, hs:3, hb:5, va:4, vf:1, vs:2, vb:3, pol:1};
        c2   = '{ha:6, hf:3, hs:2, hb:4, va:3, vf:2, vs:1, vb:2, pol:2};
        cmin = '{ha:1, hf:1, hs:1, hb:1, va:1, vf:1, vs:1, vb:1, pol:3};

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2 reset state, R1 mode cleared
        chk("R2 reset de", int'(de), 0);
        chk("R2 reset pos_x", int'(pos_x), 0);
        chk("R2 reset pos_y", int'(pos_y), 0);
        chk("R2 reset hsync", int'(hsync), 1);
        chk("R2 reset vsync", int'(vsync), 1);
        chk("R1 reset mode", int'(hdmi_mode), 0);

        // R3 packed writes while stopped, then R9 mid-frame rewrite to c2
        load_cfg(c1);
        repeat (3) @(negedge clk);
        write_reg(3'd0, 32'h8000_0000);
        sweep(c1, c2, 130, 422, "sweep1");

        // R10 stop mid-frame: idle at once; c2 polarity is vsync active-high
        write_reg(3'd0, 32'h0);
        chk("R10 stop pos_x", int'(pos_x), 0);
        chk("R10 stop pos_y", int'(pos_y), 0);
        chk("R10 stop de", int'(de), 0);
        chk("R2 stop hsync", int'(hsync), 1);
        chk("R2 stop vsync", int'(vsync), 0);

        // R7 polarity while stopped sets inactive levels
        write_reg(3'd5, 32'd3);
        @(negedge clk);
        chk("R7 idle hsync high-act", int'(hsync), 0);
        chk("R7 idle vsync high-act", int'(vsync), 0);
        write_reg(3'd5, 32'd0);
        @(negedge clk);
        chk("R7 idle hsync low-act", int'(hsync), 1);
        chk("R7 idle vsync low-act", int'(vsync), 1);

        // R1 mode flag passes through while stopped
        write_reg(3'd0, 32'h4000_0000);
        chk("R1 mode set", int'(hdmi_mode), 1);
        chk("R1 still idle de", int'(de), 0);

        // Minimum geometry
        load_cfg(cmin);
        repeat (3) @(negedge clk);
        write_reg(3'd0, 32'h8000_0000);
        chk("R1 mode clear", int'(hdmi_mode), 0);
        sweep(cmin, cmin, -1, 31, "min");

        // R10 stop mid-frame and restart at origin
        write_reg(3'd0, 32'h0);
        chk("R10 stopped de", int'(de), 0);
        write_reg(3'd0, 32'h8000_0000);
        sweep(cmin, cmin, -1, 12, "R10 restart");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", ncheck, nfail);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            ncheck++;
            nfail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", ncheck, nfail);
            $finish;
        end
    end
endmodule